// File: doc/BRIEF.md
# Vendor Request Register Bridge

This block sits between the control-transfer logic of a USB-to-serial adapter and its serial engine. Each host control request reaches it already split into a request type, a request code, a payload length and up to four payload bytes. The block decodes that request and applies it to a small set of serial-port registers: a baud divisor, a line-control byte, a modem-control byte and a flag that makes transmission wait for CTS. It answers the two read requests, for line control and modem status, with one response byte. Requests it cannot match are refused with a stall pulse.

The block also tracks the four modem input lines (carrier detect, ring indicator, data set ready, clear to send). From them it builds a modem status byte with current levels and sticky change flags. That byte and the line status byte from the serial engine together form a two-byte status report for the interrupt endpoint. The configured register values go straight to the serial engine, together with a transmit-enable that applies the CTS gate.

Top module: `vreq_uart_bridge`

## Requirements
- R1: While and after reset, baud_div = 12, line_ctrl = 0x03, modem_ctrl = 0x08, cts_hold = 0, and req_ack, req_stall and rsp_valid are 0.
- R2: A request with type 0x40, code 5 and length 4 loads baud_div from req_data, with byte 0 in bits 7:0 as the least significant byte. The new value is visible after the clock edge that accepts it.
- R3: Type 0x40, code 7, length 1 writes req_data[7:0] into line_ctrl. Type 0xC0, code 6, length 1 returns line_ctrl on rsp_data with rsp_valid high for one cycle after the accepting edge.
- R4: Type 0x40, code 10, length 1 writes req_data[7:0] into modem_ctrl.
- R5: Type 0x40, code 12, length 1 with a data byte of 0 or 1 sets cts_hold to that value. tx_enable is 0 exactly when cts_hold is 1 and the sampled CTS is low. Any other data byte is refused.
- R6: Type 0x40, code 11, length 1 is acknowledged, produces no response, and leaves every register unchanged whatever its data byte.
- R7: Every request yields exactly one of req_ack or req_stall, pulsed in the cycle after the accepting edge. An unknown code, a wrong type for the code or a wrong length gives req_stall and changes no register.
- R8: Type 0xC0, code 2, length 1 returns the modem status byte: bit 7 carrier detect, bit 6 ring indicator, bit 5 data set ready, bit 4 CTS (sampled levels), bit 3 carrier change, bit 2 ring trailing edge, bit 1 data-set-ready change, bit 0 CTS change. The read clears the four change bits, except for a change sampled in the same cycle.
- R9: The carrier, data-set-ready and CTS change bits set on any sampled transition. The ring bit sets only when the ring indicator goes from 1 to 0. Levels are sampled one clock after the input. No change bit sets on the first sample after reset.
- R10: status_rpt[7:0] holds the current modem status byte and status_rpt[15:8] holds line_stat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One decoded request is present this cycle |
| req_type | input | 8 | Request type byte (0x40 write, 0xC0 read) |
| req_code | input | 8 | Request code |
| req_len | input | 8 | Payload length in bytes |
| req_data | input | 32 | Payload, byte 0 in bits 7:0 |
| mdm_dcd | input | 1 | Carrier detect line, active high |
| mdm_ri | input | 1 | Ring indicator line, active high |
| mdm_dsr | input | 1 | Data set ready line, active high |
| mdm_cts | input | 1 | Clear to send line, active high |
| line_stat | input | 8 | Line status byte from the serial engine |
| req_ack | output | 1 | Request accepted (one-cycle pulse) |
| req_stall | output | 1 | Request refused (one-cycle pulse) |
| rsp_valid | output | 1 | Response byte valid (one-cycle pulse) |
| rsp_data | output | 8 | Response byte for a read request |
| baud_div | output | 32 | Baud divisor |
| line_ctrl | output | 8 | Line control byte |
| modem_ctrl | output | 8 | Modem control byte |
| cts_hold | output | 1 | Transmission waits for CTS when 1 |
| tx_enable | output | 1 | Serial engine may transmit |
| status_rpt | output | 16 | Status report: modem status low byte, line status high byte |

## Verification
The decoder is tried with each valid type, code and length triple. Each valid request is then mutated in one field at a time: wrong type, wrong length, an unused code, an out-of-range gate byte. This separates a stall caused by the code from one caused by the type/length pairing, and shows that refused requests leave the registers untouched. The modem status path is driven with single-line transitions in both directions, so a rising ring edge (which must not set its bit) is told apart from a falling one. Back-to-back status reads show that a read clears the change bits. The CTS gate is exercised with both flag values against both CTS levels.

// File: rtl/vrb_pkg.sv
package vrb_pkg;

    localparam logic [7:0] RT_HOST_OUT = 8'h40;
    localparam logic [7:0] RT_HOST_IN  = 8'hC0;

    localparam logic [7:0] CODE_RD_MSTAT = 8'd2;
    localparam logic [7:0] CODE_WR_DIV   = 8'd5;
    localparam logic [7:0] CODE_RD_LCTL  = 8'd6;
    localparam logic [7:0] CODE_WR_LCTL  = 8'd7;
    localparam logic [7:0] CODE_WR_MCTL  = 8'd10;
    localparam logic [7:0] CODE_NOP      = 8'd11;
    localparam logic [7:0] CODE_CTS_GATE = 8'd12;

    typedef enum logic [2:0] {
        OP_REFUSE,
        OP_DIV_WR,
        OP_LCTL_WR,
        OP_LCTL_RD,
        OP_MCTL_WR,
        OP_MSTAT_RD,
        OP_GATE_WR,
        OP_IGNORE
    } op_e;

    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } mlines_t;

    function automatic op_e classify(input logic [7:0] rtype,
                                     input logic [7:0] code,
                                     input logic [7:0] len,
                                     input logic [7:0] byte0,
                                     input logic [7:0] div_len);
        op_e op;
        op = OP_REFUSE;
        if (rtype == RT_HOST_OUT) begin
            case (code)
                CODE_WR_DIV:   if (len == div_len) op = OP_DIV_WR;
                CODE_WR_LCTL:  if (len == 8'd1) op = OP_LCTL_WR;
                CODE_WR_MCTL:  if (len == 8'd1) op = OP_MCTL_WR;
                CODE_NOP:      if (len == 8'd1) op = OP_IGNORE;
                CODE_CTS_GATE: if (len == 8'd1 && byte0[7:1] == 7'd0) op = OP_GATE_WR;
                default:       op = OP_REFUSE;
            endcase
        end else if (rtype == RT_HOST_IN) begin
            case (code)
                CODE_RD_LCTL:  if (len == 8'd1) op = OP_LCTL_RD;
                CODE_RD_MSTAT: if (len == 8'd1) op = OP_MSTAT_RD;
                default:       op = OP_REFUSE;
            endcase
        end
        return op;
    endfunction

endpackage

// File: rtl/vrb_decode.sv
module vrb_decode
    import vrb_pkg::*;
#(
    parameter int PAY_BYTES = 4
) (
    input  logic [7:0] rtype,
    input  logic [7:0] code,
    input  logic [7:0] len,
    input  logic [7:0] byte0,
    output op_e        op
);
    localparam logic [7:0] DIV_LEN = 8'(PAY_BYTES);

    always_comb op = classify(rtype, code, len, byte0, DIV_LEN);
endmodule

// File: rtl/vrb_regs.sv
module vrb_regs
    import vrb_pkg::*;
#(
    parameter int   PAY_BYTES  = 4,
    parameter int   DIV_RESET  = 12,
    parameter logic [7:0] LCTL_RESET = 8'h03,
    parameter logic [7:0] MCTL_RESET = 8'h08
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   valid,
    input  op_e                    op,
    input  logic [8*PAY_BYTES-1:0] data,
    output logic [8*PAY_BYTES-1:0] div_q,
    output logic [7:0]             lctl_q,
    output logic [7:0]             mctl_q,
    output logic                   gate_q
);
    localparam int DIV_W = 8 * PAY_BYTES;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= DIV_W'(DIV_RESET);
            lctl_q <= LCTL_RESET;
            mctl_q <= MCTL_RESET;
            gate_q <= 1'b0;
        end else if (valid) begin
            case (op)
                OP_DIV_WR:  div_q  <= data;
                OP_LCTL_WR: lctl_q <= data[7:0];
                OP_MCTL_WR: mctl_q <= data[7:0];
                OP_GATE_WR: gate_q <= data[0];
                default: ;
            endcase
        end
    end

    // R1: reset values
    p_reset_vals_r1: assert property (@(posedge clk)
        rst |=> (div_q == DIV_W'(DIV_RESET) && lctl_q == LCTL_RESET &&
                 mctl_q == MCTL_RESET && !gate_q));

    // R6, R7: refused or ignored requests leave every register alone
    p_no_side_effect_r7: assert property (@(posedge clk) disable iff (rst)
        (!valid || op == OP_REFUSE || op == OP_IGNORE) |=>
            ($stable(div_q) && $stable(lctl_q) && $stable(mctl_q) && $stable(gate_q)));
endmodule

// File: rtl/vrb_mstat.sv
module vrb_mstat
    import vrb_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  mlines_t lines_i,
    input  logic    rd_clr,
    output logic [7:0] mstat,
    output logic    cts_q
);
    mlines_t    lines_q;
    logic       primed;
    logic [3:0] chg_q;
    logic [3:0] evt;

    always_comb begin
        evt[3] = primed && (lines_q.dcd != lines_i.dcd);
        evt[2] = primed && lines_q.ri && !lines_i.ri;
        evt[1] = primed && (lines_q.dsr != lines_i.dsr);
        evt[0] = primed && (lines_q.cts != lines_i.cts);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lines_q <= lines_i;
            primed  <= 1'b0;
            chg_q   <= 4'd0;
        end else begin
            lines_q <= lines_i;
            primed  <= 1'b1;
            chg_q   <= (rd_clr ? 4'd0 : chg_q) | evt;
        end
    end

    assign mstat = {lines_q.dcd, lines_q.ri, lines_q.dsr, lines_q.cts, chg_q};
    assign cts_q = lines_q.cts;

    // R8: a read with no concurrent event leaves all change bits clear
    p_read_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && evt == 4'd0) |=> (mstat[3:0] == 4'd0));

    // R9: a falling ring indicator sets the trailing-edge bit
    p_ring_trail_r9: assert property (@(posedge clk) disable iff (rst)
        (primed && lines_q.ri && !lines_i.ri) |=> mstat[2]);

    // R9: a rising ring indicator alone never sets the trailing-edge bit
    p_ring_rise_r9: assert property (@(posedge clk) disable iff (rst)
        (!lines_q.ri && lines_i.ri && !mstat[2]) |=> !mstat[2]);
endmodule

// File: rtl/vreq_uart_bridge.sv
module vreq_uart_bridge
    import vrb_pkg::*;
#(
    parameter int PAY_BYTES = 4,
    parameter int DIV_RESET = 12
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    input  logic [7:0]             req_type,
    input  logic [7:0]             req_code,
    input  logic [7:0]             req_len,
    input  logic [8*PAY_BYTES-1:0] req_data,
    input  logic                   mdm_dcd,
    input  logic                   mdm_ri,
    input  logic                   mdm_dsr,
    input  logic                   mdm_cts,
    input  logic [7:0]             line_stat,
    output logic                   req_ack,
    output logic                   req_stall,
    output logic                   rsp_valid,
    output logic [7:0]             rsp_data,
    output logic [8*PAY_BYTES-1:0] baud_div,
    output logic [7:0]             line_ctrl,
    output logic [7:0]             modem_ctrl,
    output logic                   cts_hold,
    output logic                   tx_enable,
    output logic [15:0]            status_rpt
);
    op_e        op;
    logic [7:0] mstat;
    logic       cts_q;
    logic       is_read;
    mlines_t    lines_in;

    assign lines_in = '{dcd: mdm_dcd, ri: mdm_ri, dsr: mdm_dsr, cts: mdm_cts};
    assign is_read  = (op == OP_LCTL_RD) || (op == OP_MSTAT_RD);

    vrb_decode #(.PAY_BYTES(PAY_BYTES)) u_decode (
        .rtype(req_type), .code(req_code), .len(req_len),
        .byte0(req_data[7:0]), .op(op)
    );

    vrb_regs #(.PAY_BYTES(PAY_BYTES), .DIV_RESET(DIV_RESET)) u_regs (
        .clk(clk), .rst(rst), .valid(req_valid), .op(op), .data(req_data),
        .div_q(baud_div), .lctl_q(line_ctrl), .mctl_q(modem_ctrl), .gate_q(cts_hold)
    );

    vrb_mstat u_mstat (
        .clk(clk), .rst(rst), .lines_i(lines_in),
        .rd_clr(req_valid && op == OP_MSTAT_RD),
        .mstat(mstat), .cts_q(cts_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_ack   <= 1'b0;
            req_stall <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_data  <= 8'd0;
        end else begin
            req_ack   <= req_valid && (op != OP_REFUSE);
            req_stall <= req_valid && (op == OP_REFUSE);
            rsp_valid <= req_valid && is_read;
            if (req_valid && is_read)
                rsp_data <= (op == OP_LCTL_RD) ? line_ctrl : mstat;
        end
    end

    assign tx_enable  = !cts_hold || cts_q;
    assign status_rpt = {line_stat, mstat};

    // R7: each request resolves to exactly one outcome
    p_one_outcome_r7: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (req_ack != req_stall));

    // R7: no outcome pulse without a request
    p_no_spurious_r7: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!req_ack && !req_stall && !rsp_valid));

    // R3: a response only accompanies an accepted request
    p_rsp_with_ack_r3: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> req_ack);

    // R5: gate held with CTS low blocks transmission
    p_gate_blocks_r5: assert property (@(posedge clk) disable iff (rst)
        (cts_hold && !status_rpt[4]) |-> !tx_enable);
endmodule

// File: tb/vreq_uart_bridge_tb.sv
`timescale 1ns/1ps
module vreq_uart_bridge_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [7:0]  req_type, req_code, req_len;
    logic [31:0] req_data;
    logic        mdm_dcd, mdm_ri, mdm_dsr, mdm_cts;
    logic [7:0]  line_stat;
    logic        req_ack, req_stall, rsp_valid, cts_hold, tx_enable;
    logic [7:0]  rsp_data, line_ctrl, modem_ctrl;
    logic [31:0] baud_div;
    logic [15:0] status_rpt;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic        s_ack, s_stall, s_rv;
    logic [7:0]  s_rd;

    always #2 clk = ~clk;

    vreq_uart_bridge u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_type(req_type),
        .req_code(req_code), .req_len(req_len), .req_data(req_data),
        .mdm_dcd(mdm_dcd), .mdm_ri(mdm_ri), .mdm_dsr(mdm_dsr), .mdm_cts(mdm_cts),
        .line_stat(line_stat), .req_ack(req_ack), .req_stall(req_stall),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .baud_div(baud_div),
        .line_ctrl(line_ctrl), .modem_ctrl(modem_ctrl), .cts_hold(cts_hold),
        .tx_enable(tx_enable), .status_rpt(status_rpt)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic ceq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, tag, act, exp);
    endtask

    // drive at a falling edge, sample after the next rising edge
    task automatic send(input logic [7:0] t, input logic [7:0] c,
                        input logic [7:0] l, input logic [31:0] d);
        req_valid = 1'b1; req_type = t; req_code = c; req_len = l; req_data = d;
        @(negedge clk);
        s_ack = req_ack; s_stall = req_stall; s_rv = rsp_valid; s_rd = rsp_data;
        req_valid = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic t_reset();
        ceq("R1 baud_div", baud_div, 32'd12);
        ceq("R1 line_ctrl", {24'd0, line_ctrl}, 32'h03);
        ceq("R1 modem_ctrl", {24'd0, modem_ctrl}, 32'h08);
        ceq("R1 cts_hold", {31'd0, cts_hold}, 32'd0);
        ceq("R1 pulses", {29'd0, req_ack, req_stall, rsp_valid}, 32'd0);
        ceq("R10 reset report", {16'd0, status_rpt}, 32'h6000);
    endtask

    task automatic t_divisor();
        send(8'h40, 8'd5, 8'd4, 32'h0003_0180);
        ceq("R2 divisor ack", {31'd0, s_ack}, 32'd1);
        ceq("R2 divisor value", baud_div, 32'h0003_0180);
        send(8'h40, 8'd5, 8'd1, 32'h0000_0007);
        ceq("R7 short divisor stall", {31'd0, s_stall}, 32'd1);
        ceq("R7 divisor kept", baud_div, 32'h0003_0180);
    endtask

    task automatic t_lctl();
        send(8'h40, 8'd7, 8'd1, 32'h0000_001B);
        ceq("R3 lctl written", {24'd0, line_ctrl}, 32'h1B);
        send(8'hC0, 8'd6, 8'd1, 32'd0);
        ceq("R3 lctl read valid", {30'd0, s_ack, s_rv}, 32'd3);
        ceq("R3 lctl read data", {24'd0, s_rd}, 32'h1B);
        idle();
        ceq("R3 rsp one cycle", {31'd0, rsp_valid}, 32'd0);
        send(8'h40, 8'd6, 8'd1, 32'd0);
        ceq("R7 read with write type", {30'd0, s_stall, s_rv}, 32'd2);
    endtask

    task automatic t_mctl();
        send(8'h40, 8'd10, 8'd1, 32'h0000_000B);
        ceq("R4 mctl ack", {31'd0, s_ack}, 32'd1);
        ceq("R4 mctl written", {24'd0, modem_ctrl}, 32'h0B);
    endtask

    task automatic t_gate();
        mdm_cts = 1'b0; idle();
        send(8'h40, 8'd12, 8'd1, 32'd1);
        ceq("R5 gate on", {31'd0, cts_hold}, 32'd1);
        ceq("R5 blocked without cts", {31'd0, tx_enable}, 32'd0);
        mdm_cts = 1'b1; idle();
        ceq("R5 released by cts", {31'd0, tx_enable}, 32'd1);
        mdm_cts = 1'b0; idle();
        send(8'h40, 8'd12, 8'd1, 32'd0);
        ceq("R5 gate off", {31'd0, cts_hold}, 32'd0);
        ceq("R5 free without cts", {31'd0, tx_enable}, 32'd1);
        send(8'h40, 8'd12, 8'd1, 32'd2);
        ceq("R5 bad gate byte stall", {31'd0, s_stall}, 32'd1);
        ceq("R5 gate unchanged", {31'd0, cts_hold}, 32'd0);
        mdm_cts = 1'b1; idle();
    endtask

    task automatic t_nop();
        send(8'h40, 8'd11, 8'd1, 32'h0000_00FF);
        ceq("R6 nop ack", {29'd0, s_ack, s_stall, s_rv}, 32'd4);
        ceq("R6 regs kept", {baud_div[15:0], line_ctrl, modem_ctrl}, 32'h0180_1B0B);
        ceq("R6 divisor high kept", {16'd0, baud_div[31:16]}, 32'h0003);
        ceq("R6 gate kept", {31'd0, cts_hold}, 32'd0);
    endtask

    task automatic t_refuse();
        send(8'h40, 8'd9, 8'd1, 32'h0000_0055);
        ceq("R7 unknown code stall", {30'd0, s_ack, s_stall}, 32'd1);
        send(8'hC0, 8'd7, 8'd1, 32'h0000_0055);
        ceq("R7 write code with read type", {31'd0, s_stall}, 32'd1);
        send(8'h40, 8'd10, 8'd2, 32'h0000_0055);
        ceq("R7 mctl bad length", {31'd0, s_stall}, 32'd1);
        ceq("R7 regs kept", {baud_div[15:0], line_ctrl, modem_ctrl}, 32'h0180_1B0B);
    endtask

    task automatic t_mstat();
        send(8'hC0, 8'd2, 8'd1, 32'd0);
        send(8'hC0, 8'd2, 8'd1, 32'd0);
        ceq("R8 quiet status", {23'd0, s_rv, s_rd}, 32'h110);
        mdm_dcd = 1'b1; mdm_ri = 1'b1; idle();
        send(8'hC0, 8'd2, 8'd1, 32'd0);
        ceq("R9 carrier change, ring rise no flag", {24'd0, s_rd}, 32'hD8);
        send(8'hC0, 8'd2, 8'd1, 32'd0);
        ceq("R8 read cleared flags", {24'd0, s_rd}, 32'hD0);
        mdm_ri = 1'b0; mdm_dsr = 1'b1; idle();
        send(8'hC0, 8'd2, 8'd1, 32'd0);
        ceq("R9 ring trailing edge and dsr change", {24'd0, s_rd}, 32'hB6);
    endtask

    task automatic t_report();
        line_stat = 8'h9E; idle();
        ceq("R10 report", {16'd0, status_rpt}, 32'h9EB0);
        mdm_cts = 1'b0; idle();
        ceq("R10 report tracks cts change", {16'd0, status_rpt}, 32'h9EA1);
    endtask

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_type = 8'd0; req_code = 8'd0;
        req_len = 8'd0; req_data = 32'd0;
        mdm_dcd = 1'b0; mdm_ri = 1'b0; mdm_dsr = 1'b0; mdm_cts = 1'b0;
        line_stat = 8'h60;
        repeat (4) @(negedge clk);
        t_reset();
        rst = 1'b0;
        idle();
        t_divisor();
        t_lctl();
        t_mctl();
        t_gate();
        t_nop();
        t_refuse();
        t_mstat();
        t_report();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule